// File: doc/BRIEF.md
# Register Rename Table with Free List

This block removes false name dependences (write-after-read and write-after-write) between instructions by giving every new register result a fresh physical register. A small table holds, for each architectural register, the physical register written by its most recent producer. A FIFO holds the physical registers that are free. At most one decoding instruction per cycle is presented on a valid/ready request. It carries two architectural sources and an optional architectural destination. In the same cycle the block answers with the physical tags of both sources, a newly allocated physical destination, and the physical register that the destination was mapped to before.

The previous mapping travels with the instruction until it retires. At retirement a commit port returns that older physical register to the free list. A single checkpoint of the whole table, together with the free-list read position, can be taken at any cycle. A squash restores both in one cycle, so every register allocated after the checkpoint becomes free again in its original order.

Back-pressure: a request is accepted in a cycle where both `dec_valid` and `dec_ready` are high. The outputs are combinational and are valid only in that cycle. `dec_ready` may depend on `dec_has_dst` and `squash`. A requester holds its request until it is accepted. Commit, checkpoint and squash are plain single-cycle pulses that are never stalled.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds physical registers NUM_ARCH up to NUM_PHYS-1 and hands them out in ascending order.
- R2: Both sources are translated through the table as it stood before the current instruction's own remap. An instruction that reads its own destination gets the older physical tag.
- R3: An accepted instruction with `dec_has_dst`=1 receives the head of the free list on `ren_tag_dst` and the destination's previous mapping on `ren_tag_prev`. Later lookups of that architectural register return the new tag.
- R4: An accepted instruction with `dec_has_dst`=0 consumes no free register and leaves the table unchanged.
- R5: `dec_ready` is low while `squash` is high, or while the request needs a destination and the free list is empty. Otherwise it is high, so a request without a destination is still accepted when the list is empty.
- R6: A `cm_valid` pulse appends `cm_tag` to the tail of the free list. Freed tags are reallocated in first-in, first-out order, and a commit is accepted even in a squash cycle.
- R7: A `ckpt_save` pulse records the table and the free-list head as they stood before any rename accepted in that same cycle. That rename is therefore undone by a later squash.
- R8: A `squash` pulse restores the recorded table and free-list head in one cycle, so the next allocations repeat the tags handed out since the checkpoint. A `ckpt_save` in the same cycle is ignored.
- R9: Under correct use the free list never holds more than NUM_PHYS-NUM_ARCH entries, and every allocation that renames a destination returns a tag different from the previous mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode request present |
| dec_ready | output | 1 | Block can accept the request this cycle |
| dec_src_a | input | log2(NUM_ARCH) | First architectural source |
| dec_src_b | input | log2(NUM_ARCH) | Second architectural source |
| dec_has_dst | input | 1 | Instruction writes a register |
| dec_dst | input | log2(NUM_ARCH) | Architectural destination |
| ren_tag_a | output | log2(NUM_PHYS) | Physical tag of the first source |
| ren_tag_b | output | log2(NUM_PHYS) | Physical tag of the second source |
| ren_tag_dst | output | log2(NUM_PHYS) | Newly allocated physical destination |
| ren_tag_prev | output | log2(NUM_PHYS) | Previous physical mapping of the destination |
| ckpt_save | input | 1 | Record a checkpoint of table and free-list head |
| squash | input | 1 | Restore the recorded checkpoint |
| cm_valid | input | 1 | Commit returns a physical register |
| cm_tag | input | log2(NUM_PHYS) | Physical register being freed |

## Verification
The checker watches, on every cycle, the handshake rules (no acceptance during squash, a stall whenever a destination is needed and no tag is free), the one-per-allocation drop in free-list occupancy, the bound on occupancy, and the rule that a self-reading instruction sees the old tag. The bench shows what no single-cycle property can capture: the actual tag values over long sequences, first-in first-out reuse of committed registers, the checkpoint taken before a same-cycle rename, and the exact replay of allocations after a squash. It does this against its own model of the table and an append-only allocation log.

// File: rtl/rn_pkg.sv
package rn_pkg;
  // Circular increment for a ring of n slots
  function automatic int unsigned ring_next(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] look_a,
  input  logic [AW-1:0] look_b,
  input  logic [AW-1:0] look_d,
  output logic [PW-1:0] tag_a,
  output logic [PW-1:0] tag_b,
  output logic [PW-1:0] tag_d,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_tag,
  input  logic          save,
  input  logic          restore
);
  logic [PW-1:0] cur  [NUM_ARCH];
  logic [PW-1:0] snap [NUM_ARCH];

  // lookups read the registered table: the same-cycle remap is not visible
  assign tag_a = cur[look_a];
  assign tag_b = cur[look_b];
  assign tag_d = cur[look_d];

  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_entry
    localparam logic [PW-1:0] IDENT = PW'(i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur[i]  <= IDENT;
        snap[i] <= IDENT;
      end else begin
        if (restore)
          cur[i] <= snap[i];
        else if (wr_en && look_d == AW'(i))
          cur[i] <= wr_tag;
        if (save && !restore)
          snap[i] <= cur[i];
      end
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int PW    = $clog2(NUM_PHYS),
  localparam int DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_tag,
  input  logic          save,
  input  logic          restore,
  output logic [PW-1:0] head_tag,
  output logic [CW-1:0] count,
  output logic          empty
);
  import rn_pkg::*;

  logic [PW-1:0] slot [DEPTH];
  logic [IW-1:0] rd_ptr, wr_ptr, rd_saved;
  logic [CW-1:0] since_save;

  assign head_tag = slot[rd_ptr];
  assign empty    = (count == '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [PW-1:0] INIT = PW'(NUM_ARCH + i);
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot[i] <= INIT;
      else if (push && wr_ptr == IW'(i))
        slot[i] <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr     <= '0;
      wr_ptr     <= '0;
      rd_saved   <= '0;
      since_save <= '0;
      count      <= CW'(DEPTH);
    end else begin
      if (push)
        wr_ptr <= IW'(ring_next(int'(wr_ptr), DEPTH));
      if (restore) begin
        rd_ptr     <= rd_saved;
        since_save <= '0;
        count      <= count + since_save + CW'(push);
      end else begin
        if (pop)
          rd_ptr <= IW'(ring_next(int'(rd_ptr), DEPTH));
        count <= count + CW'(push) - CW'(pop);
        if (save) begin
          rd_saved   <= rd_ptr;
          since_save <= CW'(pop);
        end else begin
          since_save <= since_save + CW'(pop);
        end
      end
    end
  end
endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS - NUM_ARCH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  output logic          dec_ready,
  input  logic [AW-1:0] dec_src_a,
  input  logic [AW-1:0] dec_src_b,
  input  logic          dec_has_dst,
  input  logic [AW-1:0] dec_dst,
  output logic [PW-1:0] ren_tag_a,
  output logic [PW-1:0] ren_tag_b,
  output logic [PW-1:0] ren_tag_dst,
  output logic [PW-1:0] ren_tag_prev,
  input  logic          ckpt_save,
  input  logic          squash,
  input  logic          cm_valid,
  input  logic [PW-1:0] cm_tag
);
  logic          fl_empty;
  logic [CW-1:0] fl_cnt;
  logic          dec_fire;
  logic          alloc;

  assign dec_ready = !squash && (!dec_has_dst || !fl_empty);
  assign dec_fire  = dec_valid && dec_ready;
  assign alloc     = dec_fire && dec_has_dst;

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .look_a  (dec_src_a),
    .look_b  (dec_src_b),
    .look_d  (dec_dst),
    .tag_a   (ren_tag_a),
    .tag_b   (ren_tag_b),
    .tag_d   (ren_tag_prev),
    .wr_en   (alloc),
    .wr_tag  (ren_tag_dst),
    .save    (ckpt_save),
    .restore (squash)
  );

  rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_fl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (alloc),
    .push     (cm_valid),
    .push_tag (cm_tag),
    .save     (ckpt_save),
    .restore  (squash),
    .head_tag (ren_tag_dst),
    .count    (fl_cnt),
    .empty    (fl_empty)
  );
endmodule

// File: rtl/reg_rename_chk.sv
module reg_rename_chk #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW    = $clog2(NUM_ARCH),
  localparam int PW    = $clog2(NUM_PHYS),
  localparam int DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dec_valid,
  input logic          dec_ready,
  input logic [AW-1:0] dec_src_a,
  input logic          dec_has_dst,
  input logic [AW-1:0] dec_dst,
  input logic [PW-1:0] ren_tag_a,
  input logic [PW-1:0] ren_tag_dst,
  input logic [PW-1:0] ren_tag_prev,
  input logic          squash,
  input logic          cm_valid,
  input logic [CW-1:0] fl_cnt
);
  AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_has_dst && fl_cnt == '0) |-> !dec_ready); // R5
  AST_NO_ACCEPT_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> !dec_ready); // R8
  AST_SELF_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && dec_has_dst && dec_src_a == dec_dst)
      |-> ren_tag_a == ren_tag_prev); // R2
  AST_ALLOC_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && dec_has_dst && !cm_valid)
      |=> fl_cnt == $past(fl_cnt) - CW'(1)); // R3
  AST_NO_DST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(dec_valid && dec_ready && dec_has_dst) && !cm_valid && !squash)
      |=> $stable(fl_cnt)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cnt <= CW'(DEPTH)); // R9
  AST_FRESH_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && dec_has_dst) |-> ren_tag_dst != ren_tag_prev); // R9
endmodule

bind reg_rename reg_rename_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_valid    (dec_valid),
  .dec_ready    (dec_ready),
  .dec_src_a    (dec_src_a),
  .dec_has_dst  (dec_has_dst),
  .dec_dst      (dec_dst),
  .ren_tag_a    (ren_tag_a),
  .ren_tag_dst  (ren_tag_dst),
  .ren_tag_prev (ren_tag_prev),
  .squash       (squash),
  .cm_valid     (cm_valid),
  .fl_cnt       (fl_cnt)
);

// File: tb/reg_rename_test.sv
module reg_rename_test;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int AW = $clog2(NA);
  localparam int PW = $clog2(NP);

  typedef struct {
    bit rdy;
    bit hd;
    int ta;
    int tb;
    int td;
    int tp;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic dec_valid = 0, dec_has_dst = 0, ckpt_save = 0, squash = 0, cm_valid = 0;
  logic [AW-1:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
  logic [PW-1:0] cm_tag = '0;
  logic dec_ready;
  logic [PW-1:0] ren_tag_a, ren_tag_b, ren_tag_dst, ren_tag_prev;

  always #2 clk = ~clk;

  reg_rename #(.NUM_ARCH(NA), .NUM_PHYS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_has_dst(dec_has_dst),
    .dec_dst(dec_dst), .ren_tag_a(ren_tag_a), .ren_tag_b(ren_tag_b),
    .ren_tag_dst(ren_tag_dst), .ren_tag_prev(ren_tag_prev),
    .ckpt_save(ckpt_save), .squash(squash), .cm_valid(cm_valid), .cm_tag(cm_tag)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  exp_t expq[$];

  // bench model: table, checkpoint, append-only log of free tags
  int mdl_map[NA];
  int mdl_ck[NA];
  int flog[$];
  int head = 0;
  int ck_head = 0;
  int last_prev = 0;
  int last_dst = 0;
  int olds[$];
  string cur_req = "R1";

  task automatic chk(string req, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic step(bit dv, int s1, int s2, bit hd, int d,
                      bit sv, bit sq, bit cv, int ct, string req);
    exp_t e;
    @(posedge clk); #1;
    cur_req = req;
    dec_valid = dv; dec_src_a = AW'(s1); dec_src_b = AW'(s2);
    dec_has_dst = hd; dec_dst = AW'(d);
    ckpt_save = sv; squash = sq; cm_valid = cv; cm_tag = PW'(ct);
    e.rdy = !sq && (!hd || (flog.size() - head) > 0);
    e.hd = hd;
    e.ta = mdl_map[s1];
    e.tb = mdl_map[s2];
    e.td = (hd && e.rdy) ? flog[head] : 0;
    e.tp = mdl_map[d];
    if (dv) expq.push_back(e);
    last_prev = e.tp;
    last_dst = e.td;
    if (sq) begin
      mdl_map = mdl_ck;
      head = ck_head;
    end else begin
      if (sv) begin
        mdl_ck = mdl_map;
        ck_head = head;
      end
      if (dv && e.rdy && hd) begin
        mdl_map[d] = flog[head];
        head++;
      end
    end
    if (cv) flog.push_back(ct);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
  endtask

  // monitor: compare at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected request actual=1 expected=0", cur_req);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(cur_req, int'(dec_ready), int'(e.rdy), "dec_ready");
        if (e.rdy) begin
          chk(cur_req, int'(ren_tag_a), e.ta, "tag_a");
          chk(cur_req, int'(ren_tag_b), e.tb, "tag_b");
          if (e.hd) begin
            chk(cur_req, int'(ren_tag_dst), e.td, "tag_dst");
            chk(cur_req, int'(ren_tag_prev), e.tp, "tag_prev");
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NA; i++) begin
      mdl_map[i] = i;
      mdl_ck[i] = i;
    end
    for (int i = NA; i < NP; i++) flog.push_back(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", int'(dec_ready), 1, "ready after reset");
    // R1, R4: identity map, no allocation
    step(1, 3, 5, 0, 0, 0, 0, 0, 0, "R1");
    // R2, R3: r1 <- r1 op r2
    step(1, 1, 2, 1, 1, 0, 0, 0, 0, "R2");
    olds.push_back(last_prev);
    step(1, 1, 1, 1, 2, 0, 0, 0, 0, "R3");
    olds.push_back(last_prev);
    // R4: store-like, no destination
    step(1, 2, 1, 0, 0, 0, 0, 0, 0, "R4");
    // drain the rest of the free list
    for (int k = 3; k < 9; k++) begin
      step(1, k % NA, 1, 1, k % NA, 0, 0, 0, 0, "R3");
      olds.push_back(last_prev);
    end
    // R5: empty list stalls a destination, not a store
    step(1, 4, 4, 1, 5, 0, 0, 0, 0, "R5");
    step(1, 4, 6, 0, 0, 0, 0, 0, 0, "R5");
    // R6: commits refill in FIFO order
    step(0, 0, 0, 0, 0, 0, 0, 1, olds.pop_front(), "R6");
    step(1, 6, 0, 1, 6, 0, 0, 0, 0, "R6");
    olds.push_back(last_prev);
    step(0, 0, 0, 0, 0, 0, 0, 1, olds.pop_front(), "R6");
    step(0, 0, 0, 0, 0, 0, 0, 1, olds.pop_front(), "R6");
    // R7: checkpoint with a same-cycle rename
    step(1, 0, 1, 1, 0, 1, 0, 0, 0, "R7");
    step(1, 0, 2, 1, 1, 0, 0, 0, 0, "R7");
    step(1, 1, 0, 1, 3, 0, 0, 0, 0, "R5");
    // R8: squash with a concurrent commit; request refused
    step(1, 0, 0, 1, 4, 0, 1, 1, olds.pop_front(), "R8");
    step(1, 0, 1, 1, 0, 0, 0, 0, 0, "R8");
    step(1, 0, 3, 1, 2, 0, 0, 0, 0, "R8");
    step(1, 2, 0, 1, 7, 0, 0, 0, 0, "R6");
    idle();
    idle();
    @(negedge clk);
    chk("R8", expq.size(), 0, "pending expectations");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule